// File: doc/BRIEF.md
# Multi-Mode DDS Phase Generator

This block is the phase engine of a direct digital synthesizer. A 48-bit phase accumulator advances by a frequency tuning word on every clock. Its upper 16 bits, plus a programmable phase offset, form an in-phase phase word. A quadrature phase word is kept a quarter turn ahead of it. Both words feed sine and cosine lookup stages placed after this block.

Two tuning words, two phase offsets and a mode field are loaded through a simple synchronous write port. One keying input chooses the active tuning word in frequency-keyed mode and the active phase offset in phase-keyed mode. In single-tone mode the keying input is ignored. Every change of tuning word leaves the accumulator untouched, so the output phase never jumps.

The keying input may be asynchronous. It passes through a two-flop synchronizer before it reaches the selection logic.

Top module: `dds_iq_phase_gen`

## Requirements
- R1: On every clock the accumulator adds the active tuning word modulo 2^48. The in-phase output is the top 16 accumulator bits plus the aligned offset, so a tuning word of d·2^32 advances `phase_i_o` by d (mod 2^16) per clock.
- R2: After reset all tuning words and phase offsets are zero and the mode is single-tone. `phase_i_o` is 0 and `phase_q_o` is 0x4000, and both hold these values until registers are written.
- R3: In frequency-keyed mode (mode code 1), a low keying input selects tuning word 1 and a high keying input selects tuning word 2.
- R4: A change of the keying input never resets or jumps the phase. The new tuning word is first added at the third rising edge after the input changes, and the output shows that step one edge later.
- R5: In phase-keyed mode (mode code 2), a low keying input selects phase offset 1 and a high keying input selects phase offset 2. The frequency always comes from tuning word 1.
- R6: A 14-bit phase offset occupies the top 14 bits of the 16-bit phase word, that is, it is added as offset·4. An offset of all ones wraps `phase_q_o` past full scale.
- R7: In single-tone mode (mode code 0) and in the reserved mode code 3, tuning word 1 and phase offset 1 are used, and tuning word 2, phase offset 2 and the keying input have no effect. Frequency-keyed mode also uses phase offset 1.
- R8: `phase_q_o` always equals `phase_i_o` + 0x4000 modulo 2^16.
- R9: When `wr_en_i` is high at a rising edge, `wr_data_i` is stored at `wr_addr_i`: address 0 is tuning word 1, address 1 is tuning word 2, address 2 is phase offset 1 (bits 13:0), address 3 is phase offset 2 (bits 13:0) and address 4 is the mode (bits 1:0). When `wr_en_i` is low, nothing is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 48 | Write data |
| key_i | input | 1 | Keying input, may be asynchronous |
| phase_i_o | output | 16 | In-phase phase word |
| phase_q_o | output | 16 | Quadrature phase word |

## Verification
A register write changes the accumulator step at the next edge, and the outputs show it one edge after that. The bench therefore waits at least five clocks after each programming step before it compares the difference between two consecutive output samples with the expected step.

A keying change takes three edges to reach the accumulator and a fourth to reach the outputs. The continuity test samples on each falling edge after the change and expects the old step between the second and third samples and the new step between the third and fourth.

Offset tests run from a freshly reset accumulator with zero tuning words. In that state the outputs equal the aligned offset exactly.

// File: rtl/dds_pkg.sv
package dds_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [1:0] {
      MODE_TONE = 2'd0,
      MODE_FSK  = 2'd1,
      MODE_BPSK = 2'd2,
      MODE_RSVD = 2'd3
   } dds_mode_e;

   localparam logic [ADDR_W-1:0] ADDR_FTW1  = 3'd0;
   localparam logic [ADDR_W-1:0] ADDR_FTW2  = 3'd1;
   localparam logic [ADDR_W-1:0] ADDR_POFF1 = 3'd2;
   localparam logic [ADDR_W-1:0] ADDR_POFF2 = 3'd3;
   localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd4;
endpackage

// File: rtl/dds_regfile.sv
module dds_regfile
   import dds_pkg::*;
#(
   parameter int ACC_W  = 48,
   parameter int POFF_W = 14
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [ACC_W-1:0]  wr_data_i,
   output logic [ACC_W-1:0]  ftw1_o,
   output logic [ACC_W-1:0]  ftw2_o,
   output logic [POFF_W-1:0] poff1_o,
   output logic [POFF_W-1:0] poff2_o,
   output dds_mode_e         mode_o
);
   initial begin
      assert (ACC_W >= POFF_W) else $error("tuning word narrower than offset");
      assert (POFF_W >= 1) else $error("offset width must be positive");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ftw1_o  <= '0;
         ftw2_o  <= '0;
         poff1_o <= '0;
         poff2_o <= '0;
         mode_o  <= MODE_TONE;
      end else if (wr_en_i) begin
         unique case (wr_addr_i)
            ADDR_FTW1:  ftw1_o  <= wr_data_i;
            ADDR_FTW2:  ftw2_o  <= wr_data_i;
            ADDR_POFF1: poff1_o <= wr_data_i[POFF_W-1:0];
            ADDR_POFF2: poff2_o <= wr_data_i[POFF_W-1:0];
            ADDR_MODE:  mode_o  <= dds_mode_e'(wr_data_i[1:0]);
            default: ;
         endcase
      end
   end

   // R9: registers hold when no write strobe
   a_r9_hold_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_en_i |=> ($stable(ftw1_o) && $stable(ftw2_o) && $stable(poff1_o)
                    && $stable(poff2_o) && $stable(mode_o)));
endmodule

// File: rtl/dds_key_select.sv
module dds_key_select
   import dds_pkg::*;
#(
   parameter int ACC_W       = 48,
   parameter int POFF_W      = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              key_i,
   input  dds_mode_e         mode_i,
   input  logic [ACC_W-1:0]  ftw1_i,
   input  logic [ACC_W-1:0]  ftw2_i,
   input  logic [POFF_W-1:0] poff1_i,
   input  logic [POFF_W-1:0] poff2_i,
   output logic              key_sync_o,
   output logic [ACC_W-1:0]  ftw_act_o,
   output logic [POFF_W-1:0] poff_act_o
);
   initial begin
      assert (SYNC_STAGES >= 1) else $error("synchronizer needs a stage");
   end

   logic [SYNC_STAGES-1:0] chain_q;

   generate
      for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= key_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign key_sync_o = chain_q[SYNC_STAGES-1];

   always_comb begin
      ftw_act_o  = ftw1_i;
      poff_act_o = poff1_i;
      unique case (mode_i)
         MODE_FSK:  ftw_act_o  = key_sync_o ? ftw2_i : ftw1_i;
         MODE_BPSK: poff_act_o = key_sync_o ? poff2_i : poff1_i;
         default: ;
      endcase
   end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int ACC_W = 48,
   parameter int OUT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [ACC_W-1:0] step_i,
   output logic [OUT_W-1:0] phase_top_o
);
   initial begin
      assert (ACC_W >= OUT_W) else $error("accumulator narrower than output");
   end

   logic [ACC_W-1:0] acc_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) acc_q <= '0;
      else         acc_q <= acc_q + step_i;
   end

   assign phase_top_o = acc_q[ACC_W-1 -: OUT_W];
endmodule

// File: rtl/dds_iq_out.sv
module dds_iq_out #(
   parameter int OUT_W  = 16,
   parameter int POFF_W = 14
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [OUT_W-1:0]  phase_i,
   input  logic [POFF_W-1:0] poff_i,
   output logic [OUT_W-1:0]  i_o,
   output logic [OUT_W-1:0]  q_o
);
   localparam logic [OUT_W-1:0] QUARTER = OUT_W'(1) << (OUT_W - 2);

   initial begin
      assert (OUT_W >= 3) else $error("output too narrow for quadrature");
   end

   logic [OUT_W-1:0] off_al;

   generate
      if (POFF_W < OUT_W) begin : g_pad
         assign off_al = {poff_i, {(OUT_W-POFF_W){1'b0}}};
      end else if (POFF_W == OUT_W) begin : g_same
         assign off_al = poff_i;
      end else begin : g_trunc
         logic [POFF_W-OUT_W-1:0] unused_low;
         assign unused_low = poff_i[POFF_W-OUT_W-1:0];
         assign off_al = poff_i[POFF_W-1 -: OUT_W];
      end
   endgenerate

   logic [OUT_W-1:0] i_sum;
   assign i_sum = phase_i + off_al;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         i_o <= '0;
         q_o <= QUARTER;
      end else begin
         i_o <= i_sum;
         q_o <= i_sum + QUARTER;
      end
   end

   // R8: quadrature word a quarter turn ahead
   a_r8_quadrature: assert property (@(posedge clk_i) disable iff (!rst_ni)
      OUT_W'(q_o - i_o) == QUARTER);
endmodule

// File: rtl/dds_iq_phase_gen.sv
module dds_iq_phase_gen
   import dds_pkg::*;
#(
   parameter int ACC_W       = 48,
   parameter int OUT_W       = 16,
   parameter int POFF_W      = 14,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [ACC_W-1:0]  wr_data_i,
   input  logic              key_i,
   output logic [OUT_W-1:0]  phase_i_o,
   output logic [OUT_W-1:0]  phase_q_o
);
   logic [ACC_W-1:0]  ftw1, ftw2, ftw_act;
   logic [POFF_W-1:0] poff1, poff2, poff_act;
   dds_mode_e         mode;
   logic              key_s;
   logic [OUT_W-1:0]  acc_top;

   dds_regfile #(.ACC_W(ACC_W), .POFF_W(POFF_W)) regs_i (
      .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
      .ftw1_o(ftw1), .ftw2_o(ftw2), .poff1_o(poff1), .poff2_o(poff2),
      .mode_o(mode)
   );

   dds_key_select #(.ACC_W(ACC_W), .POFF_W(POFF_W), .SYNC_STAGES(SYNC_STAGES)) sel_i (
      .clk_i, .rst_ni, .key_i, .mode_i(mode),
      .ftw1_i(ftw1), .ftw2_i(ftw2), .poff1_i(poff1), .poff2_i(poff2),
      .key_sync_o(key_s), .ftw_act_o(ftw_act), .poff_act_o(poff_act)
   );

   dds_phase_acc #(.ACC_W(ACC_W), .OUT_W(OUT_W)) acc_i (
      .clk_i, .rst_ni, .step_i(ftw_act), .phase_top_o(acc_top)
   );

   dds_iq_out #(.OUT_W(OUT_W), .POFF_W(POFF_W)) iq_i (
      .clk_i, .rst_ni, .phase_i(acc_top), .poff_i(poff_act),
      .i_o(phase_i_o), .q_o(phase_q_o)
   );

   // R3: high key in frequency-keyed mode steps by tuning word 2
   a_r3_fsk_high_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MODE_FSK && key_s) |-> (ftw_act == ftw2));

   // R5: phase-keyed mode keeps tuning word 1, key picks offset
   a_r5_bpsk_freq_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MODE_BPSK) |-> (ftw_act == ftw1 && poff_act == (key_s ? poff2 : poff1)));

   // R7: single tone and reserved mode ignore the key
   a_r7_tone_ignores_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode == MODE_TONE || mode == MODE_RSVD) |-> (ftw_act == ftw1 && poff_act == poff1));

   // R2: outputs frozen while every tuning word is zero
   a_r2_zero_step_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ftw1 == '0 && ftw2 == '0 && $stable(poff_act)) |=> $stable(phase_i_o));
endmodule

// File: tb/dds_iq_phase_gen_tb_top.sv
module dds_iq_phase_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [47:0] wr_data = '0;
   logic        key = 1'b0;
   logic [15:0] ph_i, ph_q;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   dds_iq_phase_gen dut_i (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .key_i(key), .phase_i_o(ph_i), .phase_q_o(ph_q)
   );

   // mode(2) key(1) ftw1(48) ftw2(48) expected step(16)
   localparam int NV = 7;
   localparam logic [114:0] VEC [NV] = '{
      {2'd0, 1'b0, 48'h0001_0000_0000, 48'h0009_0000_0000, 16'h0001},
      {2'd0, 1'b1, 48'h0001_0000_0000, 48'h0009_0000_0000, 16'h0001},
      {2'd1, 1'b0, 48'h0002_0000_0000, 48'h0100_0000_0000, 16'h0002},
      {2'd1, 1'b1, 48'h0002_0000_0000, 48'h0100_0000_0000, 16'h0100},
      {2'd2, 1'b1, 48'h0003_0000_0000, 48'h0050_0000_0000, 16'h0003},
      {2'd1, 1'b1, 48'h0001_0000_0000, 48'hFFFF_0000_0000, 16'hFFFF},
      {2'd3, 1'b1, 48'h0004_0000_0000, 48'h0007_0000_0000, 16'h0004}
   };

   task automatic tick(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [47:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; key = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] s1, s2, s3, s4;
      @(negedge clk);
      // R2: reset state
      check("R2 reset i", ph_i, 16'h0000);
      check("R2 reset q", ph_q, 16'h4000);
      do_reset();
      tick(5);
      check("R2 idle i", ph_i, 16'h0000);
      check("R2 idle q", ph_q, 16'h4000);

      // R1 R3 R5 R7 R8: vector walk
      for (int v = 0; v < NV; v++) begin
         wr(3'd0, VEC[v][111:64]);
         wr(3'd1, VEC[v][63:16]);
         wr(3'd4, {46'd0, VEC[v][114:113]});
         key = VEC[v][112];
         tick(6);
         s1 = ph_i;
         tick();
         s2 = ph_i;
         check($sformatf("R1/R3/R5/R7 step vec%0d", v), s2 - s1, VEC[v][15:0]);
         check($sformatf("R8 quad vec%0d", v), ph_q - ph_i, 16'h4000);
      end

      // R4: phase continuity and key latency
      wr(3'd0, 48'h0001_0000_0000);
      wr(3'd1, 48'h0003_0000_0000);
      wr(3'd4, 48'd1);
      key = 1'b0;
      tick(6);
      key = 1'b1;
      tick(); s1 = ph_i;
      tick(); s2 = ph_i;
      tick(); s3 = ph_i;
      tick(); s4 = ph_i;
      check("R4 old step early", s2 - s1, 16'h0001);
      check("R4 old step before switch", s3 - s2, 16'h0001);
      check("R4 new step after switch", s4 - s3, 16'h0003);

      // R9: write with strobe low is ignored
      wr_en = 1'b0; wr_addr = 3'd1; wr_data = 48'h0020_0000_0000;
      tick();
      tick(5);
      s1 = ph_i; tick(); s2 = ph_i;
      check("R9 no strobe no store", s2 - s1, 16'h0003);

      // R5 R6 R7: offsets from a fresh accumulator
      do_reset();
      wr(3'd4, 48'd2);
      wr(3'd2, 48'h1555);
      wr(3'd3, 48'h3FFF);
      tick(5);
      check("R5/R6 offset1 i", ph_i, 16'h5554);
      check("R6 offset1 q", ph_q, 16'h9554);
      key = 1'b1;
      tick(6);
      check("R5/R6 offset2 i", ph_i, 16'hFFFC);
      check("R6 offset2 q wrap", ph_q, 16'h3FFC);
      wr(3'd4, 48'd0);
      tick(5);
      check("R7 tone ignores offset2", ph_i, 16'h5554);
      wr(3'd4, 48'd1);
      tick(5);
      check("R7 fsk uses offset1", ph_i, 16'h5554);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule